// File: doc/BRIEF.md
# PCI Host Outbound Cycle Translator

This block turns single accesses from a simple local bus master into cycles on a simplified PCI-style initiator port. A one-gigabyte local window is decoded. Every access that lands in it becomes exactly one bus cycle, and accesses outside it complete locally with no bus activity. A control register sets the cycle type. In memory mode the lower thirty address bits pass straight through and a two-bit register field supplies the top two. In configuration mode the local offset is read as a device/function/register triple and rebuilt into a configuration address with a one-hot device select.

The same control register sets the mode of the bus reset pin. A sticky status bit records any cycle that the bus side aborted, and software clears it by writing one. The local master always gets a completion, including after an abort, so it can never hang. Only one bus cycle is in flight at a time.

Top module: `pcih_xlate`

## Requirements
- R1: Only local addresses 0x80000000 to 0xBFFFFFFF (bits 31:30 = 2'b10) start a bus cycle. Any other access raises lb_ready for one cycle after the accepting edge, never raises bus_req, and a read returns 0xFFFFFFFF.
- R2: In memory mode, bus_addr = {hi, lb_addr[29:0]}, where hi is control register bits 3:2. bus_cmd is 0 for a read and 1 for a write, and bus_idsel is all zeros.
- R3: Control register bit 1 selects the cycle type: 1 gives configuration cycles, 0 gives memory cycles. The bit is sampled when the access is accepted.
- R4: In configuration mode the local offset carries the device number d in bits 15:11, the function in bits 10:8 and the dword register in bits 7:2. The resulting bus_addr has only bit 13+d set above bit 12, the function in bits 10:8, the register in bits 7:2, and zeros elsewhere. bus_idsel has only bit d set. bus_cmd is 2 for a read and 3 for a write.
- R5: In configuration mode, an offset with any of bits 29:20 set, or a device number above 18, is treated as device-not-found. No bus cycle starts, lb_ready pulses one cycle after acceptance, and a read returns 0xFFFFFFFF.
- R6: Control register bits 5:4 set the reset pin mode: 0 and 3 leave it undriven (pcirst_oe=0), 1 drives it low, and 2 drives it high. The outputs follow from the second clock edge after the register write.
- R7: An abort reported on any outstanding cycle sets the status bit (status register bit 0). Writing 1 to that bit clears it. Writing 0 leaves it unchanged.
- R8: A read that ends in an abort still completes on the local bus and returns 0xFFFFFFFF.
- R9: While a cycle is outstanding, bus_req stays high and bus_addr, bus_cmd and bus_wdata hold steady. Local strobes that arrive during that time are ignored.
- R10: bus_req rises after the accepting edge. lb_ready is a one-cycle pulse after the edge that sees bus_done or bus_abort, and a successful read returns bus_rdata.
- R11: Write data reaches bus_wdata unchanged, in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lb_addr | input | 32 | Local access address |
| lb_wdata | input | 32 | Local write data |
| lb_rd | input | 1 | Local read strobe (one cycle) |
| lb_wr | input | 1 | Local write strobe (one cycle) |
| lb_rdata | output | 32 | Local read data, valid with lb_ready |
| lb_ready | output | 1 | Local completion pulse |
| csr_wr | input | 1 | Control/status register write strobe |
| csr_sel | input | 1 | 0 selects the control register, 1 selects the status register |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Contents of the selected register |
| bus_req | output | 1 | Bus cycle outstanding |
| bus_cmd | output | 2 | Cycle type: 0 mem rd, 1 mem wr, 2 cfg rd, 3 cfg wr |
| bus_addr | output | 32 | Bus address |
| bus_idsel | output | 19 | One-hot device select for configuration cycles |
| bus_wdata | output | 32 | Bus write data |
| bus_rdata | input | 32 | Bus read data, valid with bus_done |
| bus_done | input | 1 | Bus cycle finished normally |
| bus_abort | input | 1 | Bus cycle aborted |
| pcirst_oe | output | 1 | Reset pin output enable |
| pcirst_val | output | 1 | Reset pin driven level |

## Verification
A request is accepted on the edge that samples its strobe, so the bench checks bus_req and every bus field at the falling edge that follows. The bench raises bus_done or bus_abort at that same falling edge. It then checks lb_ready and lb_rdata one falling edge later, and at the falling edge after that it confirms the pulse has ended. Local-only completions (outside the window, or device-not-found) are checked for lb_ready at the first falling edge after acceptance. The reset pin outputs are checked two edges after a register write. The status bit is read combinationally one time step after csr_sel changes.

// File: rtl/pcih_pkg.sv
package pcih_pkg;
  typedef enum logic [1:0] {
    CMD_MEM_RD = 2'd0,
    CMD_MEM_WR = 2'd1,
    CMD_CFG_RD = 2'd2,
    CMD_CFG_WR = 2'd3
  } bus_cmd_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } seq_state_e;

  typedef enum logic [1:0] {
    PRST_INPUT = 2'd0,
    PRST_LOW   = 2'd1,
    PRST_HIGH  = 2'd2,
    PRST_RSVD  = 2'd3
  } prst_mode_e;
endpackage

// File: rtl/pcih_decode.sv
module pcih_decode #(
  parameter int unsigned AW         = 32,
  parameter int unsigned WIN_BITS   = 30,
  parameter int unsigned WIN_TAG    = 2,
  parameter int unsigned NDEV       = 19,
  parameter int unsigned IDSEL_LSB  = 13,
  parameter int unsigned DEV_LSB    = 11,
  parameter int unsigned DEV_W      = 5,
  parameter int unsigned FN_LSB     = 8,
  parameter int unsigned FN_W       = 3,
  parameter int unsigned REG_LSB    = 2,
  parameter int unsigned REG_W      = 6,
  parameter int unsigned SPAN_BITS  = 20
) (
  input  logic [AW-1:0]          addr,
  input  logic                   is_wr,
  input  logic                   cfg_mode,
  input  logic [AW-WIN_BITS-1:0] hi_bits,
  output logic                   fwd,
  output logic [1:0]             cmd,
  output logic [AW-1:0]          baddr,
  output logic [NDEV-1:0]        idsel
);
  localparam int unsigned TAG_W = AW - WIN_BITS;

  logic             in_win;
  logic             span_ok;
  logic             dev_ok;
  logic [DEV_W-1:0] dev;
  logic [FN_W-1:0]  fn;
  logic [REG_W-1:0] rg;
  logic [NDEV-1:0]  idsel_oh;
  logic [AW-1:0]    cfg_addr;
  logic [AW-1:0]    mem_addr;

  assign in_win  = (addr[AW-1:WIN_BITS] == TAG_W'(WIN_TAG));
  assign span_ok = (addr[WIN_BITS-1:SPAN_BITS] == '0);
  assign dev     = addr[DEV_LSB +: DEV_W];
  assign fn      = addr[FN_LSB +: FN_W];
  assign rg      = addr[REG_LSB +: REG_W];
  assign dev_ok  = (dev < DEV_W'(NDEV));

  for (genvar g = 0; g < NDEV; g++) begin : g_idsel
    assign idsel_oh[g] = dev_ok && (dev == DEV_W'(g));
  end

  always_comb begin
    cfg_addr = '0;
    cfg_addr[IDSEL_LSB +: NDEV] = idsel_oh;
    cfg_addr[FN_LSB +: FN_W]    = fn;
    cfg_addr[REG_LSB +: REG_W]  = rg;
  end

  assign mem_addr = {hi_bits, addr[WIN_BITS-1:0]};

  always_comb begin
    fwd   = in_win && (!cfg_mode || (span_ok && dev_ok));
    cmd   = {cfg_mode, is_wr};
    baddr = cfg_mode ? cfg_addr : mem_addr;
    idsel = cfg_mode ? idsel_oh : '0;
  end
endmodule

// File: rtl/pcih_csr.sv
module pcih_csr #(
  parameter int unsigned DW     = 32,
  parameter int unsigned HI_W   = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            csr_wr,
  input  logic            csr_sel,
  input  logic [DW-1:0]   csr_wdata,
  input  logic            abort_set,
  output logic [DW-1:0]   csr_rdata,
  output logic            cfg_mode,
  output logic [HI_W-1:0] hi_bits,
  output logic            abort_st,
  output logic            pcirst_oe,
  output logic            pcirst_val
);
  import pcih_pkg::*;

  localparam int unsigned CFG_BIT  = 1;
  localparam int unsigned HI_LSB   = 2;
  localparam int unsigned MODE_LSB = HI_LSB + HI_W;
  localparam int unsigned USED_W   = MODE_LSB + 2;

  prst_mode_e       mode_q;
  logic [HI_W-1:0]  hi_q;
  logic             cfg_q;
  logic             abort_q;
  logic             wr_ctl;
  logic             wr_sts;
  logic             unused_wbits;

  assign wr_ctl = csr_wr && !csr_sel;
  assign wr_sts = csr_wr && csr_sel;
  assign unused_wbits = ^{csr_wdata[DW-1:USED_W], csr_wdata[0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= PRST_INPUT;
      hi_q   <= '0;
      cfg_q  <= 1'b0;
    end else if (wr_ctl) begin
      mode_q <= prst_mode_e'(csr_wdata[MODE_LSB +: 2]);
      hi_q   <= csr_wdata[HI_LSB +: HI_W];
      cfg_q  <= csr_wdata[CFG_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      abort_q <= 1'b0;
    end else begin
      abort_q <= abort_set | (abort_q & ~(wr_sts & csr_wdata[0]));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pcirst_oe  <= 1'b0;
      pcirst_val <= 1'b0;
    end else begin
      pcirst_oe  <= (mode_q == PRST_LOW) || (mode_q == PRST_HIGH);
      pcirst_val <= (mode_q == PRST_HIGH);
    end
  end

  always_comb begin
    csr_rdata = '0;
    if (csr_sel) begin
      csr_rdata[0] = abort_q;
    end else begin
      csr_rdata[MODE_LSB +: 2]  = mode_q;
      csr_rdata[HI_LSB +: HI_W] = hi_q;
      csr_rdata[CFG_BIT]        = cfg_q;
    end
  end

  assign cfg_mode = cfg_q;
  assign hi_bits  = hi_q;
  assign abort_st = abort_q;
endmodule

// File: rtl/pcih_xlate.sv
module pcih_xlate #(
  parameter int unsigned AW       = 32,
  parameter int unsigned DW       = 32,
  parameter int unsigned WIN_BITS = 30,
  parameter int unsigned NDEV     = 19
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [AW-1:0]   lb_addr,
  input  logic [DW-1:0]   lb_wdata,
  input  logic            lb_rd,
  input  logic            lb_wr,
  output logic [DW-1:0]   lb_rdata,
  output logic            lb_ready,
  input  logic            csr_wr,
  input  logic            csr_sel,
  input  logic [DW-1:0]   csr_wdata,
  output logic [DW-1:0]   csr_rdata,
  output logic            bus_req,
  output logic [1:0]      bus_cmd,
  output logic [AW-1:0]   bus_addr,
  output logic [NDEV-1:0] bus_idsel,
  output logic [DW-1:0]   bus_wdata,
  input  logic [DW-1:0]   bus_rdata,
  input  logic            bus_done,
  input  logic            bus_abort,
  output logic            pcirst_oe,
  output logic            pcirst_val
);
  import pcih_pkg::*;

  localparam int unsigned HI_W = AW - WIN_BITS;

  seq_state_e      state_q;
  logic            is_rd_q;
  logic            cfg_mode;
  logic [HI_W-1:0] hi_bits;
  logic            abort_st;
  logic            abort_set;
  logic            accept;
  logic            dec_fwd;
  logic [1:0]      dec_cmd;
  logic [AW-1:0]   dec_addr;
  logic [NDEV-1:0] dec_idsel;

  assign accept    = (state_q == ST_IDLE) && !lb_ready && (lb_rd || lb_wr);
  assign abort_set = (state_q == ST_WAIT) && bus_abort;

  pcih_decode #(
    .AW       (AW),
    .WIN_BITS (WIN_BITS),
    .NDEV     (NDEV)
  ) u_decode (
    .addr     (lb_addr),
    .is_wr    (!lb_rd),
    .cfg_mode (cfg_mode),
    .hi_bits  (hi_bits),
    .fwd      (dec_fwd),
    .cmd      (dec_cmd),
    .baddr    (dec_addr),
    .idsel    (dec_idsel)
  );

  pcih_csr #(
    .DW   (DW),
    .HI_W (HI_W)
  ) u_csr (
    .clk        (clk),
    .rst        (rst),
    .csr_wr     (csr_wr),
    .csr_sel    (csr_sel),
    .csr_wdata  (csr_wdata),
    .abort_set  (abort_set),
    .csr_rdata  (csr_rdata),
    .cfg_mode   (cfg_mode),
    .hi_bits    (hi_bits),
    .abort_st   (abort_st),
    .pcirst_oe  (pcirst_oe),
    .pcirst_val (pcirst_val)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      is_rd_q   <= 1'b0;
      bus_req   <= 1'b0;
      bus_cmd   <= CMD_MEM_RD;
      bus_addr  <= '0;
      bus_idsel <= '0;
      bus_wdata <= '0;
      lb_ready  <= 1'b0;
      lb_rdata  <= '0;
    end else begin
      lb_ready <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            is_rd_q <= lb_rd;
            if (dec_fwd) begin
              bus_req   <= 1'b1;
              bus_cmd   <= dec_cmd;
              bus_addr  <= dec_addr;
              bus_idsel <= dec_idsel;
              bus_wdata <= lb_wdata;
              state_q   <= ST_WAIT;
            end else begin
              lb_ready <= 1'b1;
              lb_rdata <= '1;
            end
          end
        end
        ST_WAIT: begin
          if (bus_abort) begin
            bus_req  <= 1'b0;
            lb_ready <= 1'b1;
            lb_rdata <= '1;
            state_q  <= ST_IDLE;
          end else if (bus_done) begin
            bus_req  <= 1'b0;
            lb_ready <= 1'b1;
            lb_rdata <= is_rd_q ? bus_rdata : '0;
            state_q  <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pcih_xlate_chk.sv
module pcih_xlate_chk #(
  parameter int unsigned AW   = 32,
  parameter int unsigned DW   = 32,
  parameter int unsigned NDEV = 19
) (
  input logic            clk,
  input logic            rst,
  input logic            lb_ready,
  input logic            bus_req,
  input logic [1:0]      bus_cmd,
  input logic [AW-1:0]   bus_addr,
  input logic [NDEV-1:0] bus_idsel,
  input logic [DW-1:0]   bus_wdata,
  input logic            bus_done,
  input logic            bus_abort,
  input logic            abort_st
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    bus_req && !bus_done && !bus_abort |=> bus_req); // R9

  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (rst)
    bus_req && !bus_done && !bus_abort |=>
      $stable(bus_addr) && $stable(bus_cmd) && $stable(bus_wdata)); // R9

  AST_MEM_NO_IDSEL: assert property (@(posedge clk) disable iff (rst)
    bus_req && !bus_cmd[1] |-> bus_idsel == '0); // R2

  AST_CFG_ONE_IDSEL: assert property (@(posedge clk) disable iff (rst)
    bus_req && bus_cmd[1] |-> $countones(bus_idsel) == 1); // R4

  AST_ABORT_STICKY: assert property (@(posedge clk) disable iff (rst)
    bus_req && bus_abort |=> abort_st); // R7

  AST_DONE_READY: assert property (@(posedge clk) disable iff (rst)
    bus_req && (bus_done || bus_abort) |=> lb_ready && !bus_req); // R10

  AST_READY_PULSE: assert property (@(posedge clk) disable iff (rst)
    lb_ready |=> !lb_ready); // R10
endmodule

bind pcih_xlate pcih_xlate_chk #(.AW(AW), .DW(DW), .NDEV(NDEV)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .lb_ready  (lb_ready),
  .bus_req   (bus_req),
  .bus_cmd   (bus_cmd),
  .bus_addr  (bus_addr),
  .bus_idsel (bus_idsel),
  .bus_wdata (bus_wdata),
  .bus_done  (bus_done),
  .bus_abort (bus_abort),
  .abort_st  (abort_st)
);

// File: tb/pcih_xlate_bench.sv
module pcih_xlate_bench;
  localparam int NDEV = 19;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [31:0]     lb_addr = '0;
  logic [31:0]     lb_wdata = '0;
  logic            lb_rd = 1'b0;
  logic            lb_wr = 1'b0;
  logic [31:0]     lb_rdata;
  logic            lb_ready;
  logic            csr_wr = 1'b0;
  logic            csr_sel = 1'b0;
  logic [31:0]     csr_wdata = '0;
  logic [31:0]     csr_rdata;
  logic            bus_req;
  logic [1:0]      bus_cmd;
  logic [31:0]     bus_addr;
  logic [NDEV-1:0] bus_idsel;
  logic [31:0]     bus_wdata;
  logic [31:0]     bus_rdata = '0;
  logic            bus_done = 1'b0;
  logic            bus_abort = 1'b0;
  logic            pcirst_oe;
  logic            pcirst_val;

  int unsigned n_run = 0;
  int unsigned n_fail = 0;
  bit          finished = 1'b0;

  always #10 clk = ~clk;

  pcih_xlate u_pcih_xlate (
    .clk(clk), .rst(rst),
    .lb_addr(lb_addr), .lb_wdata(lb_wdata), .lb_rd(lb_rd), .lb_wr(lb_wr),
    .lb_rdata(lb_rdata), .lb_ready(lb_ready),
    .csr_wr(csr_wr), .csr_sel(csr_sel), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .bus_req(bus_req), .bus_cmd(bus_cmd), .bus_addr(bus_addr), .bus_idsel(bus_idsel),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_done(bus_done),
    .bus_abort(bus_abort), .pcirst_oe(pcirst_oe), .pcirst_val(pcirst_val)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic csr_write(input bit sel, input logic [31:0] d);
    @(negedge clk);
    csr_wr = 1'b1; csr_sel = sel; csr_wdata = d;
    @(negedge clk);
    csr_wr = 1'b0;
    @(negedge clk);
  endtask

  task automatic status_chk(input bit exp, input string tag);
    csr_sel = 1'b1;
    #1;
    chk(csr_rdata[0] == exp, tag, csr_rdata, {31'd0, exp});
    csr_sel = 1'b0;
  endtask

  task automatic access(input logic [31:0] a, input bit wr, input logic [31:0] wd,
                        input bit fwd, input logic [1:0] ecmd, input logic [31:0] eaddr,
                        input logic [NDEV-1:0] eid, input bit ab,
                        input logic [31:0] rsp, input string tag);
    @(negedge clk);
    lb_addr = a; lb_rd = !wr; lb_wr = wr; lb_wdata = wd;
    @(negedge clk);
    lb_rd = 1'b0; lb_wr = 1'b0;
    if (fwd) begin
      chk(bus_req === 1'b1, {tag, " req"}, {31'd0, bus_req}, 32'd1);
      chk(bus_cmd === ecmd, {tag, " cmd"}, {30'd0, bus_cmd}, {30'd0, ecmd});
      chk(bus_addr === eaddr, {tag, " addr"}, bus_addr, eaddr);
      chk(bus_idsel === eid, {tag, " idsel"}, 32'(bus_idsel), 32'(eid));
      if (wr) chk(bus_wdata === wd, {tag, " R11 wdata"}, bus_wdata, wd);
      chk(lb_ready === 1'b0, {tag, " R10 early ready"}, {31'd0, lb_ready}, 32'd0);
      bus_done = !ab; bus_abort = ab; bus_rdata = rsp;
      @(negedge clk);
      bus_done = 1'b0; bus_abort = 1'b0;
      chk(lb_ready === 1'b1, {tag, " R10 ready"}, {31'd0, lb_ready}, 32'd1);
      chk(bus_req === 1'b0, {tag, " R10 req drop"}, {31'd0, bus_req}, 32'd0);
      if (!wr)
        chk(lb_rdata === (ab ? 32'hFFFF_FFFF : rsp), {tag, " R8 R10 rdata"},
            lb_rdata, ab ? 32'hFFFF_FFFF : rsp);
    end else begin
      chk(bus_req === 1'b0, {tag, " no req"}, {31'd0, bus_req}, 32'd0);
      chk(lb_ready === 1'b1, {tag, " local ready"}, {31'd0, lb_ready}, 32'd1);
      if (!wr) chk(lb_rdata === 32'hFFFF_FFFF, {tag, " ones"}, lb_rdata, 32'hFFFF_FFFF);
    end
    @(negedge clk);
    chk(lb_ready === 1'b0, {tag, " R10 pulse end"}, {31'd0, lb_ready}, 32'd0);
    chk(bus_req === 1'b0, {tag, " idle"}, {31'd0, bus_req}, 32'd0);
  endtask

  function automatic logic [31:0] cfg_local(input int d, input int f, input int r);
    return 32'h8000_0000 | (32'(d) << 11) | (32'(f) << 8) | (32'(r) << 2);
  endfunction

  function automatic logic [31:0] cfg_bus(input int d, input int f, input int r);
    return (32'd1 << (13 + d)) | (32'(f) << 8) | (32'(r) << 2);
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] offs [4];
    offs[0] = 32'h0000_0000; offs[1] = 32'h3FFF_FFFC;
    offs[2] = 32'h1234_5678; offs[3] = 32'h2AAA_AAA8;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(bus_req === 1'b0 && lb_ready === 1'b0, "reset idle", {30'd0, bus_req, lb_ready}, 32'd0);
    chk(pcirst_oe === 1'b0, "R6 reset pin input after reset", {31'd0, pcirst_oe}, 32'd0);
    status_chk(1'b0, "R7 status clear after reset");

    // R2 R11: memory mode, every value of the high field
    for (int hb = 0; hb < 4; hb++) begin
      csr_write(1'b0, 32'(hb) << 2);
      for (int k = 0; k < 4; k++) begin
        for (int w = 0; w < 2; w++) begin
          logic [31:0] a;
          a = 32'h8000_0000 | (offs[k] & 32'h3FFF_FFFF);
          access(a, w[0], 32'hA5A5_0000 ^ a, 1'b1, w[0] ? 2'd1 : 2'd0,
                 (32'(hb) << 30) | (a & 32'h3FFF_FFFF), '0, 1'b0,
                 32'h1357_0000 + 32'(k), "R2 mem");
        end
      end
    end

    // R1: window edges
    csr_write(1'b0, 32'h0);
    access(32'h8000_0000, 1'b0, 0, 1'b1, 2'd0, 32'h0000_0000, '0, 1'b0, 32'hCAFE_0001, "R1 low edge");
    access(32'hBFFF_FFFC, 1'b0, 0, 1'b1, 2'd0, 32'h3FFF_FFFC, '0, 1'b0, 32'hCAFE_0002, "R1 high edge");
    access(32'h7FFF_FFFC, 1'b0, 0, 1'b0, 0, 0, '0, 1'b0, 0, "R1 below");
    access(32'hC000_0000, 1'b0, 0, 1'b0, 0, 0, '0, 1'b0, 0, "R1 above");
    access(32'h0000_0000, 1'b1, 32'h55, 1'b0, 0, 0, '0, 1'b0, 0, "R1 zero wr");
    access(32'hFFFF_FFFC, 1'b0, 0, 1'b0, 0, 0, '0, 1'b0, 0, "R1 top");

    // R3 R4: configuration mode, every device number
    csr_write(1'b0, 32'h2);
    for (int d = 0; d < NDEV; d++) begin
      int f; int r;
      f = d % 8; r = (d * 7 + 3) % 64;
      access(cfg_local(d, f, r), d[0], 32'h0F0F_0000 + 32'(d), 1'b1,
             d[0] ? 2'd3 : 2'd2, cfg_bus(d, f, r), NDEV'(1) << d, 1'b0,
             32'hBEEF_0000 + 32'(d), "R3 R4 cfg");
    end

    // R5: device-not-found cases
    for (int d = NDEV; d < 32; d++)
      access(cfg_local(d, 1, 2), 1'b0, 0, 1'b0, 0, 0, '0, 1'b0, 0, "R5 dev>18");
    access(cfg_local(2, 0, 0) | 32'h0010_0000, 1'b0, 0, 1'b0, 0, 0, '0, 1'b0, 0, "R5 span 1MB");
    access(cfg_local(2, 0, 0) | 32'h2000_0000, 1'b1, 0, 1'b0, 0, 0, '0, 1'b0, 0, "R5 span top");
    access(32'h4000_2000, 1'b0, 0, 1'b0, 0, 0, '0, 1'b0, 0, "R1 cfg outside window");

    // R3: back to memory mode
    csr_write(1'b0, 32'h0);
    access(cfg_local(3, 1, 1), 1'b0, 0, 1'b1, 2'd0, cfg_local(3, 1, 1) & 32'h3FFF_FFFF,
           '0, 1'b0, 32'h0000_1111, "R3 mem again");

    // R7 R8: aborts
    access(32'h8000_0040, 1'b0, 0, 1'b1, 2'd0, 32'h40, '0, 1'b1, 32'h1234_5678, "R8 abort read");
    status_chk(1'b1, "R7 status set");
    csr_write(1'b1, 32'h0);
    status_chk(1'b1, "R7 write zero keeps");
    csr_write(1'b1, 32'h1);
    status_chk(1'b0, "R7 write one clears");
    csr_write(1'b0, 32'h2);
    access(cfg_local(5, 2, 9), 1'b1, 32'h77, 1'b1, 2'd3, cfg_bus(5, 2, 9), NDEV'(1) << 5,
           1'b1, 0, "R7 abort cfg write");
    status_chk(1'b1, "R7 status set on write");
    csr_write(1'b1, 32'h1);
    status_chk(1'b0, "R7 cleared again");

    // R9: strobes during an outstanding cycle are ignored
    csr_write(1'b0, 32'h0);
    @(negedge clk);
    lb_addr = 32'h8000_0100; lb_wr = 1'b1; lb_wdata = 32'hD00D_0001;
    @(negedge clk);
    lb_wr = 1'b0;
    chk(bus_req === 1'b1, "R9 req up", {31'd0, bus_req}, 32'd1);
    lb_addr = 32'h8000_0200; lb_rd = 1'b1;
    @(negedge clk);
    lb_rd = 1'b0;
    chk(bus_addr === 32'h0000_0100, "R9 addr held", bus_addr, 32'h100);
    chk(bus_cmd === 2'd1, "R9 cmd held", {30'd0, bus_cmd}, 32'd1);
    chk(bus_wdata === 32'hD00D_0001, "R9 data held", bus_wdata, 32'hD00D_0001);
    @(negedge clk);
    bus_done = 1'b1;
    @(negedge clk);
    bus_done = 1'b0;
    chk(lb_ready === 1'b1, "R9 completes", {31'd0, lb_ready}, 32'd1);
    repeat (3) begin
      @(negedge clk);
      chk(bus_req === 1'b0 && lb_ready === 1'b0, "R9 ignored strobe started nothing",
          {30'd0, bus_req, lb_ready}, 32'd0);
    end

    // R6: reset pin modes
    for (int m = 0; m < 4; m++) begin
      csr_write(1'b0, (32'(m) << 4) | 32'hE);
      chk(pcirst_oe === (m == 1 || m == 2), "R6 pin enable", {31'd0, pcirst_oe},
          {31'd0, (m == 1 || m == 2)});
      if (m == 1 || m == 2)
        chk(pcirst_val === (m == 2), "R6 pin level", {31'd0, pcirst_val}, {31'd0, m == 2});
      csr_sel = 1'b0; #1;
      chk(csr_rdata === ((32'(m) << 4) | 32'hE), "R6 control readback", csr_rdata,
          (32'(m) << 4) | 32'hE);
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule